// File: doc/BRIEF.md
# Variable-Width Auto-Reload Timer/Counter

This block is one timer/counter channel for an 8-bit microcontroller subsystem, and it has two operating modes. In mode 0 the low count byte acts as a prescaler whose active width software selects, from 1 to 8 bits. The high count byte sits above that prescaler, so the total counter is 9 to 16 bits wide. After reset the channel is set up as a 13-bit counter. In mode 1 the two count bytes form one 16-bit up-counter. When that counter wraps, it reloads itself from a pair of reload bytes.

The count step comes from one of two sources. In timer mode the step is a one-cycle strobe, `tick_i`, which the system prescaler produces once every TPS+1 clocks. In counter mode the step is a falling edge on the external count pin, after that pin has been synchronized. Counting needs the run bit to be set. When the gate bit is set, counting also needs the synchronized external gate pin to be high, which lets the channel measure pulse widths. A wrap sets a sticky overflow flag, and software clears it.

Software writes the registers through a byte-wide write port:

| Address | Register |
|---|---|
| 0 | control |
| 1 | count low |
| 2 | count high |
| 3 | reload low |
| 4 | reload high |
| 5 | status |

Every register is presented on a readback output.

Top module: `vw_timer`

## Requirements
- R1: Reset sets the control byte to 8'h40 (width select 4, all other bits 0), and clears both count bytes, both reload bytes and the overflow flag. Reset is synchronous and active high.
- R2: Control bits [6:4] hold the width select w. In mode 0 (control bit 3 = 0), the active low field is bits [w:0], and the counter reaches overflow after 2^(w+9) steps. The high byte advances each time the active low field wraps. After k steps from zero, the high byte equals k>>(w+1) and the active field equals k mod 2^(w+1).
- R3: In mode 0, low-byte bits above bit w are never changed by counting or by an overflow.
- R4: A step is taken only when run (control bit 0) is 1 and either gate enable (control bit 1) is 0 or the synchronized gate pin is 1.
- R5: Setting the run bit leaves both count bytes unchanged.
- R6: In mode 1 (control bit 3 = 1), the count bytes form one 16-bit up-counter. A step taken at FFFFh loads the reload value {reload high, reload low} and sets the overflow flag.
- R7: With the reload bytes at their reset value of 0000h, mode 1 wraps from FFFFh to 0000h.
- R8: The reload bytes read back what was written. In mode 0 they have no effect: an overflow leaves the high byte at 00h.
- R9: When control bit 2 is 1, a step occurs once for each falling edge of the count pin, after a two-flop synchronizer. `tick_i` is ignored. When control bit 2 is 0, a step occurs on each cycle with `tick_i` high.
- R10: The overflow flag stays set until software writes address 5 with bit 0 = 0. Writing address 5 with bit 0 = 1 has no effect.
- R11: When an overflow and a flag clear fall in the same cycle, the flag ends up set.
- R12: A write to either count byte takes the written value and cancels that cycle's count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timer-mode step strobe from the system prescaler |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| gate_pin_i | input | 1 | External gate pin (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ovf_o | output | 1 | Sticky overflow flag |
| ctrl_o | output | 8 | Control register readback |
| cnt_lo_o | output | 8 | Count low byte |
| cnt_hi_o | output | 8 | Count high byte |
| rel_lo_o | output | 8 | Reload low byte |
| rel_hi_o | output | 8 | Reload high byte |

## Verification
The bench builds the block with its default 8-bit bytes, which gives a 3-bit width select. All eight prescaler widths can therefore be swept one after another.

For each width, the bench preloads the counter just below the wrap point. It then checks the state one step before the overflow and the state on the overflow step, with the expected period and the preserved upper low bits worked out arithmetically.

Near-wrap preloads in mode 1 bring within reach:
- reload from a non-zero value;
- the short period that a high reload value gives;
- the full 0000h wrap.

Same-cycle collisions are driven on purpose: a count write against a step, and a flag clear against an overflow.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int DW = 8;
  localparam int SW = $clog2(DW);
  localparam int AW = 3;

  typedef logic [AW-1:0] addr_t;

  localparam addr_t A_CTRL = 3'd0;
  localparam addr_t A_CLO  = 3'd1;
  localparam addr_t A_CHI  = 3'd2;
  localparam addr_t A_RLO  = 3'd3;
  localparam addr_t A_RHI  = 3'd4;
  localparam addr_t A_STAT = 3'd5;

  typedef struct packed {
    logic          spare;
    logic [SW-1:0] wsel;
    logic          mode;
    logic          ext;
    logic          gate;
    logic          run;
  } ctrl_t;

  localparam int RST_WSEL = 4;
endpackage

// File: rtl/vt_sync.sv
module vt_sync #(
  parameter int STAGES = 2,
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/vt_step.sv
module vt_step #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic gate_en_i,
  input  logic ext_sel_i,
  input  logic tick_i,
  input  logic cnt_pin_i,
  input  logic gate_pin_i,
  output logic step_o
);
  logic pin_s, gate_s, pin_prev, fall;

  vt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d_i(cnt_pin_i), .q_o(pin_s)
  );

  vt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_gate_sync (
    .clk(clk), .rst(rst), .d_i(gate_pin_i), .q_o(gate_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= 1'b1;
    else     pin_prev <= pin_s;
  end

  assign fall   = pin_prev & ~pin_s;
  assign step_o = run_i & (~gate_en_i | gate_s) & (ext_sel_i ? fall : tick_i);
endmodule

// File: rtl/vt_regs.sv
module vt_regs
  import vt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  addr_t         wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wrap_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] rel_lo_o,
  output logic [DW-1:0] rel_hi_o,
  output logic          ovf_o
);
  logic clr_req;

  assign clr_req = wr_en_i && (wr_addr_i == A_STAT) && !wr_data_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o      <= '0;
      ctrl_o.wsel <= SW'(RST_WSEL);
      rel_lo_o    <= '0;
      rel_hi_o    <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: ctrl_o   <= ctrl_t'(wr_data_i);
        A_RLO:  rel_lo_o <= wr_data_i;
        A_RHI:  rel_hi_o <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_o <= 1'b0;
    else if (wrap_i)  ovf_o <= 1'b1;
    else if (clr_req) ovf_o <= 1'b0;
  end
endmodule

// File: rtl/vt_count.sv
module vt_count
  import vt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          mode_i,
  input  logic [SW-1:0] wsel_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rel_lo_i,
  input  logic [DW-1:0] rel_hi_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          wrap_o
);
  logic [DW-1:0]   mask, lo_n, hi_n, lo_inc;
  logic [2*DW-1:0] full_inc;
  logic            lo_full, hi_full, adv;

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (i <= int'(wsel_i));
  end

  assign lo_full  = &(lo_o | ~mask);
  assign hi_full  = &hi_o;
  assign adv      = step_i & ~wr_lo_i & ~wr_hi_i;
  assign lo_inc   = lo_o + 1'b1;
  assign full_inc = {hi_o, lo_o} + 1'b1;

  always_comb begin
    lo_n   = lo_o;
    hi_n   = hi_o;
    wrap_o = 1'b0;
    if (adv) begin
      if (!mode_i) begin
        if (lo_full) begin
          lo_n   = lo_o & ~mask;
          hi_n   = hi_o + 1'b1;
          wrap_o = hi_full;
        end else begin
          lo_n = (lo_o & ~mask) | (lo_inc & mask);
        end
      end else begin
        if (lo_full && hi_full && (&lo_o)) begin
          lo_n   = rel_lo_i;
          hi_n   = rel_hi_i;
          wrap_o = 1'b1;
        end else begin
          {hi_n, lo_n} = full_inc;
        end
      end
    end
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_o <= '0;
      hi_o <= '0;
    end else begin
      lo_o <= lo_n;
      hi_o <= hi_n;
    end
  end
endmodule

// File: rtl/vw_timer.sv
module vw_timer
  import vt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          cnt_pin_i,
  input  logic          gate_pin_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          ovf_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] cnt_lo_o,
  output logic [DW-1:0] cnt_hi_o,
  output logic [DW-1:0] rel_lo_o,
  output logic [DW-1:0] rel_hi_o
);
  ctrl_t ctrl;
  logic  step_w, wrap_w, wr_lo, wr_hi;

  assign wr_lo  = wr_en_i && (wr_addr_i == A_CLO);
  assign wr_hi  = wr_en_i && (wr_addr_i == A_CHI);
  assign ctrl_o = DW'(ctrl);

  vt_regs u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wrap_i(wrap_w), .ctrl_o(ctrl),
    .rel_lo_o(rel_lo_o), .rel_hi_o(rel_hi_o), .ovf_o(ovf_o)
  );

  vt_step #(.SYNC_STAGES(2)) u_step (
    .clk(clk), .rst(rst), .run_i(ctrl.run), .gate_en_i(ctrl.gate),
    .ext_sel_i(ctrl.ext), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
    .gate_pin_i(gate_pin_i), .step_o(step_w)
  );

  vt_count u_count (
    .clk(clk), .rst(rst), .step_i(step_w), .mode_i(ctrl.mode),
    .wsel_i(ctrl.wsel), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(wr_data_i), .rel_lo_i(rel_lo_o), .rel_hi_i(rel_hi_o),
    .lo_o(cnt_lo_o), .hi_o(cnt_hi_o), .wrap_o(wrap_w)
  );
endmodule

// File: rtl/vt_chk.sv
module vt_chk
  import vt_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] ctrl_o,
  input logic [DW-1:0] cnt_lo_o,
  input logic [DW-1:0] cnt_hi_o,
  input logic [DW-1:0] rel_lo_o,
  input logic [DW-1:0] rel_hi_o,
  input logic          ovf_o,
  input logic          wrap
);
  logic cnt_wr, clr;
  assign cnt_wr = wr_en_i && (wr_addr_i == A_CLO || wr_addr_i == A_CHI);
  assign clr    = wr_en_i && (wr_addr_i == A_STAT) && !wr_data_i[0];

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cnt_lo_o == '0 && cnt_hi_o == '0 && rel_lo_o == '0 &&
             rel_hi_o == '0 && !ovf_o));

  p_run_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_o[0] && !cnt_wr) |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o)));

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (wrap && ctrl_o[3]) |=> (cnt_lo_o == $past(rel_lo_o) && cnt_hi_o == $past(rel_hi_o)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !clr) |=> ovf_o);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_o);

  p_write_prio_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == A_CLO) |=> cnt_lo_o == $past(wr_data_i));
endmodule

bind vw_timer vt_chk u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .ctrl_o(ctrl_o), .cnt_lo_o(cnt_lo_o),
  .cnt_hi_o(cnt_hi_o), .rel_lo_o(rel_lo_o), .rel_hi_o(rel_hi_o),
  .ovf_o(ovf_o), .wrap(wrap_w)
);

// File: tb/vw_timer_bench.sv
module vw_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0, cnt_pin_i = 1'b1, gate_pin_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       ovf_o;
  logic [7:0] ctrl_o, cnt_lo_o, cnt_hi_o, rel_lo_o, rel_hi_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vw_timer u_vw_timer (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 ctrl", {8'h0, ctrl_o}, 16'h0040);
    chk("R1 count", {cnt_hi_o, cnt_lo_o}, 16'h0000);
    chk("R1 reload", {rel_hi_o, rel_lo_o}, 16'h0000);
    chk("R1 flag", {15'h0, ovf_o}, 16'h0000);

    // R8 reload bytes as storage
    wr(3'd3, 8'h5A); wr(3'd4, 8'hA5);
    chk("R8 readback", {rel_hi_o, rel_lo_o}, 16'hA55A);

    // R2 R3 sweep every prescaler width
    for (int w = 0; w < 8; w++) begin
      logic [7:0] m;
      m = 8'((1 << (w + 1)) - 1);
      wr(3'd0, {1'b0, 3'(w), 4'b0001});
      wr(3'd1, ~m); wr(3'd2, 8'hFE); wr(3'd5, 8'h00);
      ticks(2 * (int'(m) + 1) - 1);
      chk("R2 pre-wrap flag", {15'h0, ovf_o}, 16'h0000);
      chk("R2 pre-wrap count", {cnt_hi_o, cnt_lo_o}, 16'hFFFF);
      ticks(1);
      chk("R2 wrap flag", {15'h0, ovf_o}, 16'h0001);
      chk("R8 hi after mode0 wrap", {8'h0, cnt_hi_o}, 16'h0000);
      chk("R3 upper low bits held", {8'h0, cnt_lo_o}, {8'h0, ~m});
    end

    // R2 full period from zero at width 0 (512 steps)
    wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd5, 8'h00);
    ticks(511);
    chk("R2 w0 pre", {15'h0, ovf_o}, 16'h0000);
    ticks(1);
    chk("R2 w0 wrap", {7'h0, ovf_o, cnt_hi_o}, 16'h0100);
    // R2 arithmetic position, w=2, 100 steps
    wr(3'd0, 8'h21); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    ticks(100);
    chk("R2 position", {cnt_hi_o, cnt_lo_o}, {8'(100 >> 3), 8'(100 & 7)});

    // R10 sticky flag
    chk("R10 still set", {15'h0, ovf_o}, 16'h0001);
    wr(3'd5, 8'hFF);
    chk("R10 write one no effect", {15'h0, ovf_o}, 16'h0001);
    wr(3'd5, 8'hFE);
    chk("R10 clear", {15'h0, ovf_o}, 16'h0000);

    // R5 setting run keeps count
    wr(3'd0, 8'h40); wr(3'd1, 8'h11); wr(3'd2, 8'h22);
    wr(3'd0, 8'h41);
    chk("R5 run keeps count", {cnt_hi_o, cnt_lo_o}, 16'h2211);
    ticks(3);
    chk("R9 tick source", {cnt_hi_o, cnt_lo_o}, 16'h2214);

    // R4 run and gate
    wr(3'd0, 8'h40);
    ticks(5);
    chk("R4 run off", {cnt_hi_o, cnt_lo_o}, 16'h2214);
    wr(3'd0, 8'h43); gate_pin_i = 1'b0; idle(3);
    ticks(5);
    chk("R4 gate low", {cnt_hi_o, cnt_lo_o}, 16'h2214);
    gate_pin_i = 1'b1; idle(3);
    ticks(5);
    chk("R4 gate high", {cnt_hi_o, cnt_lo_o}, 16'h2219);

    // R9 external pin source
    wr(3'd0, 8'h45);
    ticks(10);
    chk("R9 tick ignored", {cnt_hi_o, cnt_lo_o}, 16'h2219);
    for (int i = 0; i < 6; i++) begin
      cnt_pin_i = 1'b0; idle(3);
      cnt_pin_i = 1'b1; idle(3);
    end
    chk("R9 falling edges", {cnt_hi_o, cnt_lo_o}, 16'h221F);

    // R12 write beats step
    wr(3'd0, 8'h41);
    tick_i = 1'b1; wr(3'd1, 8'h33); tick_i = 1'b0;
    chk("R12 write priority", {cnt_hi_o, cnt_lo_o}, 16'h2233);

    // R6 mode 1 reload
    wr(3'd0, 8'h49); wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF); wr(3'd5, 8'h00);
    ticks(1);
    chk("R6 at top", {7'h0, ovf_o, 8'h0} | {cnt_hi_o, cnt_lo_o}, 16'hFFFF);
    chk("R6 no flag yet", {15'h0, ovf_o}, 16'h0000);
    ticks(1);
    chk("R6 reloaded", {cnt_hi_o, cnt_lo_o}, 16'h1234);
    chk("R6 flag", {15'h0, ovf_o}, 16'h0001);
    wr(3'd3, 8'hF0); wr(3'd4, 8'hFF);
    wr(3'd1, 8'hF0); wr(3'd2, 8'hFF); wr(3'd5, 8'h00);
    ticks(15);
    chk("R6 short period pre", {15'h0, ovf_o}, 16'h0000);
    ticks(1);
    chk("R6 short period", {7'h0, ovf_o, 8'h0} ^ {cnt_hi_o, cnt_lo_o}, 16'hFEF0);

    // R11 set beats clear
    wr(3'd5, 8'h00); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    tick_i = 1'b1; wr(3'd5, 8'h00); tick_i = 1'b0;
    chk("R11 set wins", {15'h0, ovf_o}, 16'h0001);
    chk("R11 reload", {cnt_hi_o, cnt_lo_o}, 16'hFFF0);

    // R7 default reload full wrap
    do_reset();
    wr(3'd0, 8'h49); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    ticks(1);
    chk("R7 wrap to zero", {cnt_hi_o, cnt_lo_o}, 16'h0000);
    chk("R7 flag", {15'h0, ovf_o}, 16'h0001);
    ticks(300);
    chk("R6 16-bit count", {cnt_hi_o, cnt_lo_o}, 16'd300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule